// File: doc/BRIEF.md
# Descriptor Condition Evaluation Unit

This block sits beside a descriptor-driven DMA channel engine and settles, for each descriptor that is about to complete, three separate questions: whether completion must be stalled, whether an interrupt is raised, and whether the engine follows a branch or advances sequentially. All three use the same kind of test. A 4-bit device-status field from the channel is masked and compared with a stored compare value. Each test has its own stored mask and value, held in one of three select registers. Each decision also has its own 2-bit mode field in the descriptor command word, which picks whether the test result is ignored, used as is, inverted, or overridden.

The engine presents the command word and the device status and pulses an evaluate strobe. One cycle later the block shows three results. The hold flag stays asserted while the stall condition is true. The interrupt output pulses for one cycle when the descriptor completes and an interrupt is due. The branch-taken flag is set when the branch is followed and cleared on a sequential advance. While completion is held, the interrupt and branch-taken outputs do not move. The select registers are written through a simple write port with an index.

Top module: `cond_eval_unit`

## Requirements
- R1: After synchronous reset, `irq_o`, `hold_o` and `bt_o` are 0, and all three select registers hold mask 0 and value 0. A zero mask makes every condition true.
- R2: A condition is true when (`devstat_i` AND mask) equals (value AND mask). On a select write, the mask is taken from bits 19:16 of `sel_wdata_i` and the value from bits 3:0. All other data bits are ignored.
- R3: Each mode field is decoded as 0 = never act, 1 = act if the condition is true, 2 = act if the condition is false, 3 = always act.
- R4: In `cmd_i`, the interrupt mode is bits 5:4, the branch mode is bits 3:2 and the wait mode is bits 1:0.
- R5: `irq_o` is a single-cycle pulse in the cycle after a strobe on `eval_i`. It is high only if, at that strobe, the interrupt decision was true and the wait decision was false.
- R6: At every strobe, `hold_o` takes the value of the wait decision. Between strobes it keeps its value.
- R7: A strobe whose wait decision is true raises no interrupt and leaves `bt_o` unchanged.
- R8: A strobe whose wait decision is false loads `bt_o` with the branch decision: 1 when the branch is taken, 0 on a sequential advance. Without a strobe, `bt_o` keeps its value.
- R9: A write with `sel_idx_i` 0 updates the interrupt select, 1 the wait select and 2 the branch select. A write with index 3 changes no select register.
- R10: Each decision tests the device status only against its own select register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_we_i | input | 1 | Select register write enable |
| sel_idx_i | input | 2 | Select register index: 0 interrupt, 1 wait, 2 branch |
| sel_wdata_i | input | 32 | Select write data: mask in 19:16, value in 3:0 |
| cmd_i | input | 16 | Command word of the descriptor being completed |
| devstat_i | input | 4 | Device-status field of the channel |
| eval_i | input | 1 | Evaluate strobe, one per completion attempt |
| irq_o | output | 1 | Interrupt pulse |
| hold_o | output | 1 | Completion held by the wait condition |
| bt_o | output | 1 | Branch-taken flag |

## Verification
A corrupted select register or a misdecoded mode field shows up in the cycle after the next strobe whose decision depends on it. It appears as a missing or extra interrupt pulse, a wrong hold level, or a wrong branch-taken value, so the tests put each decision next to conditions that match and conditions that do not. A wrong hold state can also be seen through its side effect. A strobe made while holding must leave the branch flag untouched and raise no interrupt. Idle cycles between strobes must leave all three outputs stable, which exposes a register that updates without a strobe.

// File: rtl/cond_eval_pkg.sv
package cond_eval_pkg;

    localparam int DEVSTAT_W = 4;
    localparam int NUM_KINDS = 3;

    typedef enum logic [1:0] {
        MODE_NEVER    = 2'd0,
        MODE_IF_TRUE  = 2'd1,
        MODE_IF_FALSE = 2'd2,
        MODE_ALWAYS   = 2'd3
    } cond_mode_e;

    // Select register index of each decision kind
    typedef enum logic [1:0] {
        KIND_IRQ    = 2'd0,
        KIND_WAIT   = 2'd1,
        KIND_BRANCH = 2'd2
    } cond_kind_e;

    // Layout of the low six bits of the command word, most significant first
    typedef struct packed {
        cond_mode_e irq;
        cond_mode_e brn;
        cond_mode_e wt;
    } mode_set_t;

    function automatic logic apply_mode(input cond_mode_e mode, input logic cond);
        logic act;
        case (mode)
            MODE_NEVER:    act = 1'b0;
            MODE_IF_TRUE:  act = cond;
            MODE_IF_FALSE: act = ~cond;
            default:       act = 1'b1;
        endcase
        return act;
    endfunction

    function automatic cond_mode_e mode_of(input mode_set_t ms, input int kind);
        cond_mode_e m;
        case (kind)
            0:       m = ms.irq;
            1:       m = ms.wt;
            default: m = ms.brn;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/cond_sel_bank.sv
module cond_sel_bank
    import cond_eval_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int STAT_W    = DEVSTAT_W,
    parameter int NUM_SEL   = NUM_KINDS,
    parameter int MASK_LSB  = 16,
    parameter int VALUE_LSB = 0,
    parameter int IDX_W     = 2
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             we_i,
    input  logic [IDX_W-1:0]                 idx_i,
    input  logic [DATA_W-1:0]                wdata_i,
    output logic [NUM_SEL-1:0][STAT_W-1:0]   mask_o,
    output logic [NUM_SEL-1:0][STAT_W-1:0]   value_o
);

    localparam int MASK_MSB  = MASK_LSB + STAT_W - 1;
    localparam int VALUE_MSB = VALUE_LSB + STAT_W - 1;

    logic [NUM_SEL-1:0][STAT_W-1:0] mask_q;
    logic [NUM_SEL-1:0][STAT_W-1:0] value_q;

    for (genvar g = 0; g < NUM_SEL; g++) begin : g_sel
        always_ff @(posedge clk) begin
            if (rst) begin
                mask_q[g]  <= '0;
                value_q[g] <= '0;
            end else if (we_i && (int'(idx_i) == g)) begin
                mask_q[g]  <= wdata_i[MASK_MSB:MASK_LSB];
                value_q[g] <= wdata_i[VALUE_MSB:VALUE_LSB];
            end
        end
    end

    assign mask_o  = mask_q;
    assign value_o = value_q;

    logic past_ok;
    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    // R9: an out-of-range index leaves every select register alone
    a_r9_unused_index: assert property (@(posedge clk) disable iff (rst)
        past_ok && $past(we_i) && (int'($past(idx_i)) >= NUM_SEL)
        |-> ($stable(mask_q) && $stable(value_q)));

    // R9: no change without a write
    a_r9_no_write_stable: assert property (@(posedge clk) disable iff (rst)
        past_ok && !$past(we_i) |-> ($stable(mask_q) && $stable(value_q)));

endmodule

// File: rtl/cond_decide.sv
module cond_decide
    import cond_eval_pkg::*;
#(
    parameter int STAT_W = DEVSTAT_W
) (
    input  cond_mode_e          mode_i,
    input  logic [STAT_W-1:0]   mask_i,
    input  logic [STAT_W-1:0]   value_i,
    input  logic [STAT_W-1:0]   devstat_i,
    output logic                cond_o,
    output logic                act_o
);

    always_comb begin
        cond_o = ((devstat_i & mask_i) == (value_i & mask_i));
        act_o  = apply_mode(mode_i, cond_o);
    end

    // R3: the fixed modes ignore the condition
    always_comb begin
        if (mode_i == MODE_NEVER)  a_r3_never:  assert (act_o == 1'b0);
        if (mode_i == MODE_ALWAYS) a_r3_always: assert (act_o == 1'b1);
    end

endmodule

// File: rtl/cond_eval_unit.sv
module cond_eval_unit
    import cond_eval_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int CMD_W     = 16,
    parameter int STAT_W    = DEVSTAT_W,
    parameter int MODE_LSB  = 0,
    parameter int MASK_LSB  = 16,
    parameter int VALUE_LSB = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_we_i,
    input  logic [1:0]        sel_idx_i,
    input  logic [DATA_W-1:0] sel_wdata_i,
    input  logic [CMD_W-1:0]  cmd_i,
    input  logic [STAT_W-1:0] devstat_i,
    input  logic              eval_i,
    output logic              irq_o,
    output logic              hold_o,
    output logic              bt_o
);

    localparam int MODES_W = $bits(mode_set_t);
    localparam int MODE_MSB = MODE_LSB + MODES_W - 1;

    logic [NUM_KINDS-1:0][STAT_W-1:0] sel_mask;
    logic [NUM_KINDS-1:0][STAT_W-1:0] sel_value;
    logic [NUM_KINDS-1:0]             cond_hit;
    logic [NUM_KINDS-1:0]             act;
    mode_set_t                        modes;

    cond_sel_bank #(
        .DATA_W    (DATA_W),
        .STAT_W    (STAT_W),
        .NUM_SEL   (NUM_KINDS),
        .MASK_LSB  (MASK_LSB),
        .VALUE_LSB (VALUE_LSB),
        .IDX_W     (2)
    ) i_sel_bank (
        .clk     (clk),
        .rst     (rst),
        .we_i    (sel_we_i),
        .idx_i   (sel_idx_i),
        .wdata_i (sel_wdata_i),
        .mask_o  (sel_mask),
        .value_o (sel_value)
    );

    assign modes = mode_set_t'(cmd_i[MODE_MSB:MODE_LSB]);

    for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
        cond_decide #(.STAT_W(STAT_W)) i_decide (
            .mode_i    (mode_of(modes, k)),
            .mask_i    (sel_mask[k]),
            .value_i   (sel_value[k]),
            .devstat_i (devstat_i),
            .cond_o    (cond_hit[k]),
            .act_o     (act[k])
        );
    end

    logic wait_now;
    logic irq_now;
    logic brn_now;

    always_comb begin
        wait_now = act[KIND_WAIT];
        irq_now  = act[KIND_IRQ] & ~wait_now;
        brn_now  = act[KIND_BRANCH];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_o  <= 1'b0;
            hold_o <= 1'b0;
            bt_o   <= 1'b0;
        end else begin
            irq_o <= eval_i & irq_now;
            if (eval_i) begin
                hold_o <= wait_now;
                if (!wait_now) bt_o <= brn_now;
            end
        end
    end

    logic past_ok;
    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    // R5: a pulse only follows a strobe
    a_r5_irq_after_eval: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> $past(eval_i));

    // R7: no interrupt on a held completion
    a_r7_no_irq_when_held: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> !hold_o);

    // R7: branch flag frozen when the strobe was held
    a_r7_bt_frozen: assert property (@(posedge clk) disable iff (rst)
        past_ok && $past(eval_i) && hold_o |-> $stable(bt_o));

    // R6: hold level kept between strobes
    a_r6_hold_stable: assert property (@(posedge clk) disable iff (rst)
        past_ok && !$past(eval_i) |-> $stable(hold_o));

    // R8: branch flag kept between strobes
    a_r8_bt_stable: assert property (@(posedge clk) disable iff (rst)
        past_ok && !$past(eval_i) |-> $stable(bt_o));

endmodule

// File: tb/test_cond_eval_unit.sv
module test_cond_eval_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel_we = 1'b0;
    logic [1:0]  sel_idx = '0;
    logic [31:0] sel_wdata = '0;
    logic [15:0] cmd = '0;
    logic [3:0]  devstat = '0;
    logic        eval = 1'b0;
    logic        irq, hold, bt;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [3:0] m_mask [3];
    logic [3:0] m_val  [3];
    bit         m_bt;
    bit         m_hold;

    always #10 clk = ~clk;

    cond_eval_unit i_cond_eval_unit (
        .clk(clk), .rst(rst), .sel_we_i(sel_we), .sel_idx_i(sel_idx),
        .sel_wdata_i(sel_wdata), .cmd_i(cmd), .devstat_i(devstat),
        .eval_i(eval), .irq_o(irq), .hold_o(hold), .bt_o(bt)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    function automatic bit decide(input int k, input logic [1:0] mode, input logic [3:0] ds);
        bit c = ((ds & m_mask[k]) == (m_val[k] & m_mask[k]));
        case (mode)
            2'd0: return 1'b0;
            2'd1: return c;
            2'd2: return !c;
            default: return 1'b1;
        endcase
    endfunction

    task automatic write_sel(input logic [1:0] idx, input logic [31:0] data);
        @(negedge clk);
        sel_we = 1'b1; sel_idx = idx; sel_wdata = data;
        @(negedge clk);
        sel_we = 1'b0;
        if (idx < 2'd3) begin
            m_mask[idx] = data[19:16];
            m_val[idx]  = data[3:0];
        end
    endtask

    task automatic do_eval(input string req, input logic [15:0] c, input logic [3:0] ds);
        bit w, i, b;
        w = decide(1, c[1:0], ds);
        i = decide(0, c[5:4], ds) && !w;
        b = decide(2, c[3:2], ds);
        @(negedge clk);
        cmd = c; devstat = ds; eval = 1'b1;
        @(negedge clk);
        eval = 1'b0;
        m_hold = w;
        if (!w) m_bt = b;
        check(req, "irq", irq, i);
        check(req, "hold", hold, m_hold);
        check(req, "bt", bt, m_bt);
        @(negedge clk);
        check("R5", "irq second cycle", irq, 1'b0);
    endtask

    task automatic idle_check(input string req, input int cycles);
        for (int n = 0; n < cycles; n++) begin
            @(negedge clk);
            check(req, "idle irq", irq, 1'b0);
            check(req, "idle hold", hold, m_hold);
            check(req, "idle bt", bt, m_bt);
        end
    endtask

    task automatic t_reset;
        check("R1", "irq at reset", irq, 1'b0);
        check("R1", "hold at reset", hold, 1'b0);
        check("R1", "bt at reset", bt, 1'b0);
        // zero masks: every condition true, so wait if-true holds
        do_eval("R1", 16'h0015, 4'hA);
        do_eval("R1", 16'h0014, 4'h3);
    endtask

    task automatic t_compare;
        write_sel(2'd0, {12'hABC, 4'hC, 12'h5E7, 4'h8});
        do_eval("R2", 16'h0010, 4'h8);
        do_eval("R2", 16'h0010, 4'hB);
        do_eval("R2", 16'h0010, 4'h4);
        do_eval("R2", 16'h0010, 4'h0);
    endtask

    task automatic t_modes;
        write_sel(2'd0, 32'h000F_0005);
        write_sel(2'd2, 32'h000F_0009);
        for (int m = 0; m < 4; m++) begin
            do_eval("R3", 16'(m << 4), 4'h5);
            do_eval("R3", 16'(m << 4), 4'h6);
            do_eval("R3", 16'(m << 2), 4'h9);
            do_eval("R3", 16'(m << 2), 4'h1);
        end
    endtask

    task automatic t_fields;
        write_sel(2'd0, 32'h000F_0001);
        write_sel(2'd1, 32'h000F_0002);
        write_sel(2'd2, 32'h000F_0003);
        do_eval("R4", 16'hFFD5, 4'h1);
        do_eval("R4", 16'h0015, 4'h3);
        do_eval("R10", 16'h0015, 4'h2);
        do_eval("R10", 16'h0004, 4'h1);
        do_eval("R10", 16'h0020, 4'h3);
    endtask

    task automatic t_wait;
        do_eval("R8", 16'h0008, 4'h0);
        do_eval("R7", 16'h003D, 4'h2);
        idle_check("R6", 3);
        do_eval("R7", 16'h003D, 4'h2);
        do_eval("R6", 16'h003D, 4'h0);
        idle_check("R6", 2);
    endtask

    task automatic t_branch;
        do_eval("R8", 16'h000C, 4'h0);
        idle_check("R8", 2);
        do_eval("R8", 16'h0000, 4'h0);
        do_eval("R8", 16'h0004, 4'h3);
        do_eval("R8", 16'h0004, 4'h7);
    endtask

    task automatic t_unused;
        write_sel(2'd3, 32'h0000_0000);
        do_eval("R9", 16'h0015, 4'h1);
        do_eval("R9", 16'h0015, 4'h3);
        do_eval("R9", 16'h0015, 4'h2);
        write_sel(2'd1, 32'h0003_FFF1);
        do_eval("R9", 16'h0001, 4'h5);
        do_eval("R9", 16'h0001, 4'h6);
    endtask

    initial begin
        for (int k = 0; k < 3; k++) begin m_mask[k] = '0; m_val[k] = '0; end
        m_bt = 1'b0; m_hold = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_compare;
        t_modes;
        t_fields;
        t_wait;
        t_branch;
        t_unused;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule